// File: doc/BRIEF.md
# Receive Packet Buffer with Level-Based Availability

This block sits between a link-layer writer and a user-side reader on the receive path. Every accepted word is stored along with its framing side information: a start-of-packet mark, an end-of-packet mark, an error mark, the number of unused bytes in the word, and a packet tag. The reader drains words through a request/valid handshake. A request in one cycle yields the word, marked valid, in the next cycle.

An availability output tells the reader when to begin draining. It rises once the stored word count goes above a programmable low level. An optional mode also raises it whenever at least one end-of-packet word is held. In that mode a packet shorter than the level still gets pulled out instead of waiting in the buffer. Both the level and the mode are captured while reset is held and are ignored after reset.

Back-pressure works as follows. The writer is never stalled. A word offered while the buffer already holds its full depth is dropped, and an overflow pulse follows one cycle later. The reader throttles itself: it may request on any cycle, and it normally waits for the availability flag before doing so. A request made while the buffer is empty is ignored. It produces no valid word and raises an empty-read pulse one cycle later. Everything runs on a single clock with a synchronous active-low reset.

Top module: `pkt_rx_buffer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rd_valid`, `avail`, `empty_read` and `overflow` are all low.
- R2: Words are read out in the order they were accepted. Each word keeps its data, `sop`, `eop`, `err` and empty-byte count intact, and the error mark may sit on any word of a packet.
- R3: A read request taken at a clock edge while the buffer is non-empty makes `rd_valid` high for exactly the following cycle, carrying the oldest word. When `rd_en` is low at an edge, `rd_valid` is low in the following cycle.
- R4: When the availability mode is 0, `avail` is high exactly when the stored word count is strictly greater than the captured low level. The level is counted in words.
- R5: When the availability mode is 1, `avail` is also high whenever at least one stored word carries end-of-packet, even if the count is at or below the level.
- R6: A read request while the buffer holds no word is ignored. `rd_valid` stays low, `empty_read` is high for the one following cycle, and later reads return the stored words unchanged.
- R7: A write offered while the buffer holds DEPTH words is dropped. `overflow` is high for the one following cycle, and the words already stored read back unchanged, with nothing extra.
- R8: `rd_id` carries the stored packet tag only on a valid word whose `rd_sop` is 1. On any other valid word it reads 0.
- R9: `cfg_low_level` and `cfg_eop_mode` are sampled only while `rst_n` is low. Changing them after reset has no effect on `avail`.
- R10: A cycle with both a write and a read request, on a buffer that is neither empty nor full, stores the new word and delivers the oldest one. The stored word count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration is captured while low |
| cfg_low_level | input | CNT_W | Low fill level, in words, above which `avail` rises |
| cfg_eop_mode | input | 1 | 1: a stored end-of-packet word also raises `avail` |
| wr_valid | input | 1 | Writer offers a word this cycle |
| wr_data | input | 8*DATA_BYTES | Word payload |
| wr_sop | input | 1 | Word starts a packet |
| wr_eop | input | 1 | Word ends a packet |
| wr_err | input | 1 | Word is marked in error |
| wr_empty | input | EMPTY_W | Unused bytes in the word |
| wr_id | input | ID_W | Packet tag, meaningful with `wr_sop` |
| rd_en | input | 1 | Read request; the word appears in the next cycle |
| rd_valid | output | 1 | Read outputs carry a word this cycle |
| rd_data | output | 8*DATA_BYTES | Word payload |
| rd_sop | output | 1 | Start-of-packet mark |
| rd_eop | output | 1 | End-of-packet mark |
| rd_err | output | 1 | Error mark |
| rd_empty | output | EMPTY_W | Unused bytes in the word |
| rd_id | output | ID_W | Packet tag on start words, else 0 |
| avail | output | 1 | Data-available flag for the reader |
| empty_read | output | 1 | One-cycle pulse: the previous request found the buffer empty |
| overflow | output | 1 | One-cycle pulse: the previous write was dropped |

## Verification
The bench builds the block with DATA_BYTES=4, DEPTH=8 and ID_W=4. The shallow depth means nine writes reach the full-buffer drop. Eight writes under a level of 7 bring the boundary between count-equal-to-level and count-above-level into a short test. Reset is applied again between scenarios with different levels and modes, so both availability modes, the eop override draining a two-word packet below the level, and a configuration change after reset are all exercised in one run.

// File: rtl/pkt_rx_buffer_pkg.sv
package pkt_rx_buffer_pkg;

  typedef enum logic {
    AVAIL_LEVEL_ONLY   = 1'b0,
    AVAIL_LEVEL_OR_EOP = 1'b1
  } avail_mode_e;

  localparam int unsigned SIDE_FLAG_BITS = 3;

endpackage

// File: rtl/pkt_rx_store.sv
module pkt_rx_store #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned ENTRY_W = 48,
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic [ENTRY_W-1:0] wr_word,
  input  logic               rd_req,
  output logic               push_ok,
  output logic               pop_ok,
  output logic [ENTRY_W-1:0] head_word,
  output logic [CNT_W-1:0]   level
);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr;
  logic [PTR_W-1:0]   rd_ptr;
  logic               full;
  logic               empty;

  assign full      = (level == CNT_W'(DEPTH));
  assign empty     = (level == '0);
  assign push_ok   = wr_req && !full;
  assign pop_ok    = rd_req && !empty;
  assign head_word = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) begin
        if (wr_ptr == PTR_W'(DEPTH - 1)) wr_ptr <= '0;
        else                             wr_ptr <= wr_ptr + 1'b1;
      end
      if (pop_ok) begin
        if (rd_ptr == PTR_W'(DEPTH - 1)) rd_ptr <= '0;
        else                             rd_ptr <= rd_ptr + 1'b1;
      end
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R7: the stored count never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  // R7: a write into a full buffer with no read leaves it full, not beyond
  a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !rd_req) |=> (level == CNT_W'(DEPTH)));

  // R10: a simultaneous write and read on a partly filled buffer keeps the count
  a_r10_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && rd_req && !full && !empty) |=> $stable(level));

endmodule

// File: rtl/pkt_rx_eop_tracker.sv
module pkt_rx_eop_tracker #(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eop_in,
  input  logic             eop_out,
  input  logic [CNT_W-1:0] level,
  output logic             eop_held
);

  logic [CNT_W-1:0] eop_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eop_cnt <= '0;
    end else begin
      case ({eop_in, eop_out})
        2'b10:   eop_cnt <= eop_cnt + 1'b1;
        2'b01:   eop_cnt <= eop_cnt - 1'b1;
        default: eop_cnt <= eop_cnt;
      endcase
    end
  end

  assign eop_held = (eop_cnt != '0);

  // R5: the end-of-packet tally can never exceed the number of stored words
  a_r5_eop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    eop_cnt <= level);

endmodule

// File: rtl/pkt_rx_avail_gen.sv
module pkt_rx_avail_gen
  import pkt_rx_buffer_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_low_level,
  input  logic             cfg_eop_mode,
  input  logic [CNT_W-1:0] level,
  input  logic             eop_held,
  output logic             avail
);

  logic [CNT_W-1:0] low_q;
  avail_mode_e      mode_q;
  logic             above_low;
  logic             eop_force;

  // configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= cfg_low_level;
      mode_q <= avail_mode_e'(cfg_eop_mode);
    end
  end

  assign above_low = (level > low_q);
  assign eop_force = (mode_q == AVAIL_LEVEL_OR_EOP) && eop_held;
  assign avail     = above_low || eop_force;

  // R4: with the override off, the flag follows the level comparison only
  a_r4_level_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == AVAIL_LEVEL_ONLY && level <= low_q) |-> !avail);

  // R5: a held end-of-packet word raises the flag in override mode
  a_r5_eop_override: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == AVAIL_LEVEL_OR_EOP && eop_held) |-> avail);

endmodule

// File: rtl/pkt_rx_buffer.sv
module pkt_rx_buffer
  import pkt_rx_buffer_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 4,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned ID_W       = 8,
  localparam int unsigned DATA_W    = 8 * DATA_BYTES,
  localparam int unsigned EMPTY_W   = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_low_level,
  input  logic               cfg_eop_mode,
  input  logic               wr_valid,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_sop,
  input  logic               wr_eop,
  input  logic               wr_err,
  input  logic [EMPTY_W-1:0] wr_empty,
  input  logic [ID_W-1:0]    wr_id,
  input  logic               rd_en,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_sop,
  output logic               rd_eop,
  output logic               rd_err,
  output logic [EMPTY_W-1:0] rd_empty,
  output logic [ID_W-1:0]    rd_id,
  output logic               avail,
  output logic               empty_read,
  output logic               overflow
);

  localparam int unsigned ENTRY_W = DATA_W + SIDE_FLAG_BITS + EMPTY_W + ID_W;
  localparam int unsigned ID_LSB  = 0;
  localparam int unsigned EMP_LSB = ID_LSB + ID_W;
  localparam int unsigned ERR_BIT = EMP_LSB + EMPTY_W;
  localparam int unsigned EOP_BIT = ERR_BIT + 1;
  localparam int unsigned SOP_BIT = EOP_BIT + 1;
  localparam int unsigned DAT_LSB = SOP_BIT + 1;

  logic [ENTRY_W-1:0] wr_word;
  logic [ENTRY_W-1:0] head_word;
  logic               push_ok;
  logic               pop_ok;
  logic [CNT_W-1:0]   level;
  logic               eop_held;

  assign wr_word = {wr_data, wr_sop, wr_eop, wr_err, wr_empty, wr_id};

  pkt_rx_store #(
    .DEPTH   (DEPTH),
    .ENTRY_W (ENTRY_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_valid),
    .wr_word   (wr_word),
    .rd_req    (rd_en),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .head_word (head_word),
    .level     (level)
  );

  pkt_rx_eop_tracker #(
    .DEPTH (DEPTH)
  ) u_eop (
    .clk      (clk),
    .rst_n    (rst_n),
    .eop_in   (push_ok && wr_eop),
    .eop_out  (pop_ok && head_word[EOP_BIT]),
    .level    (level),
    .eop_held (eop_held)
  );

  pkt_rx_avail_gen #(
    .DEPTH (DEPTH)
  ) u_avail (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_low_level (cfg_low_level),
    .cfg_eop_mode  (cfg_eop_mode),
    .level         (level),
    .eop_held      (eop_held),
    .avail         (avail)
  );

  // read-side output register: one cycle from request to valid word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rd_sop     <= 1'b0;
      rd_eop     <= 1'b0;
      rd_err     <= 1'b0;
      rd_empty   <= '0;
      rd_id      <= '0;
      empty_read <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      rd_valid   <= pop_ok;
      empty_read <= rd_en && !pop_ok;
      overflow   <= wr_valid && !push_ok;
      if (pop_ok) begin
        rd_data  <= head_word[DAT_LSB +: DATA_W];
        rd_sop   <= head_word[SOP_BIT];
        rd_eop   <= head_word[EOP_BIT];
        rd_err   <= head_word[ERR_BIT];
        rd_empty <= head_word[EMP_LSB +: EMPTY_W];
        rd_id    <= head_word[SOP_BIT] ? head_word[ID_LSB +: ID_W] : '0;
      end
    end
  end

  // R6: a request on an empty buffer gives no word and flags the empty read
  a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0) |=> (!rd_valid && empty_read));

  // R3: no request, no valid word in the next cycle
  a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R8: the tag is zero on any valid word that does not start a packet
  a_r8_id_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_sop) |-> (rd_id == '0));

  // R7: the overflow pulse only follows an offered write
  a_r7_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !overflow);

endmodule

// File: tb/pkt_rx_buffer_bench.sv
`timescale 1ns/1ps
module pkt_rx_buffer_bench;

  localparam int DATA_BYTES = 4;
  localparam int DEPTH      = 8;
  localparam int ID_W       = 4;
  localparam int DATA_W     = 8 * DATA_BYTES;
  localparam int EMPTY_W    = 2;
  localparam int CNT_W      = 4;
  localparam int EW         = DATA_W + 3 + EMPTY_W + ID_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [CNT_W-1:0]   cfg_low_level = '0;
  logic               cfg_eop_mode = 1'b0;
  logic               wr_valid = 1'b0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic               wr_sop = 1'b0, wr_eop = 1'b0, wr_err = 1'b0;
  logic [EMPTY_W-1:0] wr_empty = '0;
  logic [ID_W-1:0]    wr_id = '0;
  logic               rd_en = 1'b0;
  logic               rd_valid, rd_sop, rd_eop, rd_err;
  logic [DATA_W-1:0]  rd_data;
  logic [EMPTY_W-1:0] rd_empty;
  logic [ID_W-1:0]    rd_id;
  logic               avail, empty_read, overflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int cur_low  = 0;
  bit cur_mode = 1'b0;
  logic [EW-1:0] model_q[$];

  always #10 clk = ~clk;

  pkt_rx_buffer #(
    .DATA_BYTES (DATA_BYTES),
    .DEPTH      (DEPTH),
    .ID_W       (ID_W)
  ) u_pkt_rx_buffer (
    .clk (clk), .rst_n (rst_n),
    .cfg_low_level (cfg_low_level), .cfg_eop_mode (cfg_eop_mode),
    .wr_valid (wr_valid), .wr_data (wr_data), .wr_sop (wr_sop), .wr_eop (wr_eop),
    .wr_err (wr_err), .wr_empty (wr_empty), .wr_id (wr_id),
    .rd_en (rd_en), .rd_valid (rd_valid), .rd_data (rd_data), .rd_sop (rd_sop),
    .rd_eop (rd_eop), .rd_err (rd_err), .rd_empty (rd_empty), .rd_id (rd_id),
    .avail (avail), .empty_read (empty_read), .overflow (overflow)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_avail();
    bit any_eop = 1'b0;
    foreach (model_q[i]) if (model_q[i][ID_W + EMPTY_W + 1]) any_eop = 1'b1;
    return (model_q.size() > cur_low) || (cur_mode && any_eop);
  endfunction

  task automatic do_reset(input int low, input bit mode);
    @(negedge clk);
    rst_n = 1'b0; cfg_low_level = CNT_W'(low); cfg_eop_mode = mode;
    cur_low = low; cur_mode = mode;
    model_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "rd_valid after reset", 64'(rd_valid), 64'd0);
    check("R1", "avail after reset", 64'(avail), 64'd0);
    check("R1", "empty_read after reset", 64'(empty_read), 64'd0);
    check("R1", "overflow after reset", 64'(overflow), 64'd0);
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic push(input logic [DATA_W-1:0] d, input bit s, input bit e,
                      input bit er, input logic [EMPTY_W-1:0] em,
                      input logic [ID_W-1:0] id);
    wr_valid = 1'b1; wr_data = d; wr_sop = s; wr_eop = e; wr_err = er;
    wr_empty = em; wr_id = id;
    if (model_q.size() < DEPTH) model_q.push_back({d, s, e, er, em, id});
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop_check(input string req);
    logic [EW-1:0] w;
    bit had = (model_q.size() > 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (had) begin
      w = model_q.pop_front();
      check(req, "rd_valid", 64'(rd_valid), 64'd1);
      check("R2", "rd_data", 64'(rd_data), 64'(w[EW-1 -: DATA_W]));
      check("R2", "rd_sop", 64'(rd_sop), 64'(w[ID_W + EMPTY_W + 2]));
      check("R2", "rd_eop", 64'(rd_eop), 64'(w[ID_W + EMPTY_W + 1]));
      check("R2", "rd_err", 64'(rd_err), 64'(w[ID_W + EMPTY_W]));
      check("R2", "rd_empty", 64'(rd_empty), 64'(w[ID_W +: EMPTY_W]));
      check("R8", "rd_id", 64'(rd_id),
            w[ID_W + EMPTY_W + 2] ? 64'(w[ID_W-1:0]) : 64'd0);
    end else begin
      check("R6", "rd_valid on empty read", 64'(rd_valid), 64'd0);
      check("R6", "empty_read pulse", 64'(empty_read), 64'd1);
    end
  endtask

  task automatic t_order();
    do_reset(2, 1'b0);
    push(32'hA0A0_0001, 1, 0, 0, 2'd0, 4'h5);
    check("R4", "avail at 1 word", 64'(avail), 64'(model_avail()));
    push(32'hA0A0_0002, 0, 0, 1, 2'd0, 4'h7);
    check("R4", "avail at 2 words (level 2)", 64'(avail), 64'd0);
    push(32'hA0A0_0003, 0, 1, 0, 2'd3, 4'h9);
    check("R4", "avail at 3 words (level 2)", 64'(avail), 64'd1);
    pop_check("R3");
    check("R4", "avail after one read", 64'(avail), 64'(model_avail()));
    pop_check("R3");
    pop_check("R3");
    @(negedge clk);
    check("R3", "rd_valid with rd_en low", 64'(rd_valid), 64'd0);
  endtask

  task automatic t_eop_mode();
    do_reset(5, 1'b1);
    push(32'hB000_0001, 1, 0, 0, 2'd0, 4'h3);
    check("R5", "avail, one non-eop word", 64'(avail), 64'd0);
    push(32'hB000_0002, 0, 1, 0, 2'd1, 4'h0);
    check("R5", "avail, eop held below level", 64'(avail), 64'd1);
    pop_check("R5");
    check("R5", "avail, eop still held", 64'(avail), 64'd1);
    pop_check("R5");
    check("R5", "avail after eop drained", 64'(avail), 64'd0);
    do_reset(5, 1'b0);
    push(32'hB000_0003, 1, 1, 0, 2'd2, 4'h1);
    check("R4", "avail, eop held with override off", 64'(avail), 64'd0);
    pop_check("R2");
  endtask

  task automatic t_empty_read();
    do_reset(0, 1'b0);
    pop_check("R6");
    @(negedge clk);
    check("R6", "empty_read lasts one cycle", 64'(empty_read), 64'd0);
    push(32'hC0DE_0001, 1, 1, 1, 2'd1, 4'hE);
    check("R4", "avail at 1 word (level 0)", 64'(avail), 64'd1);
    pop_check("R6");
  endtask

  task automatic t_overflow();
    do_reset(7, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      push(32'hD000_0000 + 32'(i), (i == 0), (i == DEPTH - 1), 0, 2'(i), 4'(i));
      check("R7", "no overflow while filling", 64'(overflow), 64'd0);
      if (i == DEPTH - 2) check("R4", "avail at count == level", 64'(avail), 64'd0);
    end
    check("R4", "avail at count > level", 64'(avail), 64'd1);
    push(32'hDEAD_BEEF, 1, 1, 1, 2'd3, 4'hF);
    check("R7", "overflow pulse", 64'(overflow), 64'd1);
    @(negedge clk);
    check("R7", "overflow lasts one cycle", 64'(overflow), 64'd0);
    for (int i = 0; i < DEPTH; i++) pop_check("R7");
    pop_check("R7");
  endtask

  task automatic t_cfg_ignored();
    do_reset(1, 1'b0);
    cfg_low_level = '0; cfg_eop_mode = 1'b1;
    push(32'hE000_0001, 1, 1, 0, 2'd0, 4'h2);
    check("R9", "avail uses level captured at reset", 64'(avail), 64'd0);
    push(32'hE000_0002, 1, 1, 0, 2'd0, 4'h4);
    check("R9", "avail above captured level", 64'(avail), 64'd1);
    pop_check("R9");
    pop_check("R9");
  endtask

  task automatic t_simul();
    logic [EW-1:0] w;
    do_reset(0, 1'b0);
    push(32'hF000_0001, 1, 0, 0, 2'd0, 4'hA);
    push(32'hF000_0002, 0, 1, 0, 2'd2, 4'hB);
    w = model_q.pop_front();
    model_q.push_back({32'hF000_0003, 1'b1, 1'b1, 1'b0, 2'd1, 4'hC});
    wr_valid = 1'b1; wr_data = 32'hF000_0003; wr_sop = 1; wr_eop = 1; wr_err = 0;
    wr_empty = 2'd1; wr_id = 4'hC; rd_en = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0;
    check("R10", "rd_valid on write+read", 64'(rd_valid), 64'd1);
    check("R10", "rd_data on write+read", 64'(rd_data), 64'(w[EW-1 -: DATA_W]));
    pop_check("R10");
    pop_check("R10");
    pop_check("R10");
  endtask

  initial begin
    t_order();
    t_eop_mode();
    t_empty_read();
    t_overflow();
    t_cfg_ignored();
    t_simul();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule